// File: doc/BRIEF.md
# Radar chirp frame packetizer

This block turns the raw data of one radar chirp into a serial-camera-style packet stream. While a chirp is acquired, the block collects one complex 12-bit sample per receive channel per sample index, and optionally a few chirp quality words. It stores them in a small line buffer. When the chirp is closed, the block sends the chirp as one line:

- a line-start short packet;
- one long packet whose payload holds the chirp profile, the chirp number, the four channels interleaved sample by sample and, when enabled, the quality words;
- a line-end short packet.

Frame boundaries produce frame-start and frame-end short packets. Every packet carries the configured virtual channel. Headers are protected by a 6-bit Hamming code, and the payload is followed by a CRC-16.

The byte stream is dealt round-robin over one, two or four output lanes. Each packet starts on lane 0. Each packet is padded with zero bytes so that all active lanes deliver its final bytes in the same cycle.

The caller must follow three usage rules:
- Keep the lane-count and virtual-channel settings stable while packets are in flight.
- Supply exactly the configured number of samples and quality words between a chirp start and a chirp end.
- Wait until a line has been sent before opening the next chirp.

Top module: `pk_chirp_packetizer`

## Requirements
- R1: After reset, all lane valid flags are 0 and all lane bytes are 0x00.
- R2: A frame-start strobe sends a 4-byte short packet. Its bytes are, in order: identifier `{vc[1:0], 6'h00}`, the low byte of a 16-bit frame counter, the high byte, then the ECC. A frame-end strobe sends the same form with type 6'h01. The frame counter is 0 after reset and increments after each frame-end packet.
- R3: A chirp-end strobe sends three packets in this order: a line-start short packet (type 6'h02), the long packet, and a line-end short packet (type 6'h03). Both short packets carry the latched chirp number as their 16-bit field, low byte first.
- R4: The long-packet header is: identifier `{vc, 6'h2C}`, the word count (low byte, then high byte), then the ECC.
- R5: The payload starts with the 16-bit chirp profile and then the 16-bit chirp number, each sent low byte first. Both are latched at the chirp-start strobe.
- R6: Samples follow in arrival order. For each sample index, channels 0 to 3 are sent in turn, 3 bytes each: `I[7:0]`, `{Q[3:0], I[11:8]}`, `Q[11:4]`. On the `smp_data` input, channel c occupies bits `[24c +: 24]`, with I in the low 12 bits and Q in the high 12 bits.
- R7: The quality words, each sent low byte first, are appended only when `cfg_qual_en` is 1 at the moment the line begins. The word count is 4 + 12·NSAMP, plus 2·NQUAL when quality words are included.
- R8: Two CRC bytes follow the payload, low byte first. The CRC is CRC-16 with polynomial x^16+x^12+x^5+1, reflected (0x8408), initial value 0xFFFF and no final inversion, processed LSB first over all payload bytes.
- R9: The ECC byte has bits 7:6 equal to 0. Bit k is the parity of the 24-bit header word `{field_hi, field_lo, identifier}` ANDed with mask k. The masks for k = 0 to 5 are 0xF12CB7, 0xF2555B, 0x749A6D, 0xB8E38E, 0xDF03F0 and 0xEFFC00.
- R10: Packet bytes are dealt to lanes 0, 1, … round-robin, and every packet starts on lane 0. When a packet ends before all active lanes are filled, the remaining active lanes receive 0x00. An output cycle raises the valid flag of every active lane and of no other lane.
- R11: Lane count setting `cfg_lanes`: 0 selects one lane, 1 selects two lanes, and 2 or 3 select four lanes.
- R12: When a chirp-end strobe and a frame-end strobe arrive in the same cycle, the whole line is sent before the frame-end packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_vc | input | 2 | Virtual channel placed in every identifier |
| cfg_lanes | input | 2 | Active lane count select |
| cfg_qual_en | input | 1 | Include quality words in the line payload |
| frame_start | input | 1 | Frame-open strobe |
| frame_end | input | 1 | Frame-close strobe |
| chirp_start | input | 1 | Chirp-open strobe; latches profile and number, rewinds buffers |
| chirp_profile | input | 16 | Chirp profile identifier |
| chirp_num | input | 16 | Chirp counter value |
| chirp_end | input | 1 | Chirp-close strobe; requests the line |
| smp_valid | input | 1 | One sample index of all channels present |
| smp_data | input | 96 | Four complex 12-bit samples |
| qual_valid | input | 1 | Quality word present |
| qual_word | input | 16 | Chirp quality word |
| lane_data | output | 32 | Lane k byte at bits [8k +: 8] |
| lane_valid | output | 4 | Per-lane byte valid |

## Verification
The bench builds the block with five sample indices and three quality words. With these sizes the line packet is 70 bytes without quality data and 76 bytes with it. Against four lanes, one of these lengths needs zero padding and the other does not, so both the padded and the exact endings of R10 are exercised. The bench runs every lane setting, including the alias value 3, several virtual channels, and both quality modes. It also runs a frame end that coincides with a chirp end. Short packets and headers are checked byte by byte against ECC and CRC values that the bench computes on its own.

// File: rtl/pk_pkt_pkg.sv
package pk_pkt_pkg;

  localparam logic [5:0] DT_FS = 6'h00;
  localparam logic [5:0] DT_FE = 6'h01;
  localparam logic [5:0] DT_LS = 6'h02;
  localparam logic [5:0] DT_LE = 6'h03;

  typedef enum logic [2:0] {S_IDLE, S_SP, S_LH, S_PL, S_CRC} seq_st_t;
  typedef enum logic [1:0] {PH_INFO, PH_SMP, PH_QUAL} pl_ph_t;

  localparam logic [23:0] ECC_MASK [6] = '{24'hF12CB7, 24'hF2555B, 24'h749A6D,
                                           24'hB8E38E, 24'hDF03F0, 24'hEFFC00};

  function automatic logic [7:0] hdr_ecc(input logic [23:0] d);
    logic [7:0] e;
    e = 8'h00;
    for (int k = 0; k < 6; k++) e[k] = ^(d & ECC_MASK[k]);
    return e;
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

endpackage

// File: rtl/pk_line_ram.sv
module pk_line_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pk_byte_seq.sv
module pk_byte_seq
  import pk_pkt_pkg::*;
#(
  parameter int NSAMP   = 16,
  parameter int NQUAL   = 2,
  parameter int SBYTES  = 12,
  parameter logic [5:0] LONG_DT = 6'h2C,
  parameter int SAW     = (NSAMP > 1) ? $clog2(NSAMP) : 1,
  parameter int QAW     = (NQUAL > 1) ? $clog2(NQUAL) : 1,
  parameter int SBW     = (SBYTES > 1) ? $clog2(SBYTES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          vc,
  input  logic                qual_en,
  input  logic                frame_start,
  input  logic                frame_end,
  input  logic                chirp_end,
  input  logic [15:0]         prof,
  input  logic [15:0]         num,
  input  logic [SBYTES*8-1:0] smp_rdata,
  input  logic [15:0]         qual_rdata,
  output logic [SAW-1:0]      smp_raddr,
  output logic [QAW-1:0]      qual_raddr,
  output logic                ob_valid,
  output logic [7:0]          ob_data,
  output logic                ob_last
);
  seq_st_t st, st_d;
  pl_ph_t  ph, ph_d;
  logic [5:0]     dt, dt_d;
  logic [1:0]     cnt, cnt_d;
  logic [SAW-1:0] sidx, sidx_d;
  logic [SBW-1:0] sb, sb_d;
  logic [QAW-1:0] qidx, qidx_d;
  logic           qb, qb_d;
  logic           qen, qen_d;
  logic [15:0]    fcnt, fcnt_d, crc, crc_d;
  logic           pend_fs, pend_ln, pend_fe;
  logic           take_fs, take_ln, take_fe, emit, last;
  logic [7:0]     byte_c;
  logic [7:0]     di;
  logic [15:0]    field, wc;

  assign wc = 16'(4 + SBYTES * NSAMP) + (qen ? 16'(2 * NQUAL) : 16'd0);
  assign field = (dt == DT_LS || dt == DT_LE) ? num : fcnt;
  assign smp_raddr  = sidx_d;
  assign qual_raddr = qidx_d;

  always_comb begin
    st_d = st; ph_d = ph; dt_d = dt; cnt_d = cnt; sidx_d = sidx; sb_d = sb;
    qidx_d = qidx; qb_d = qb; qen_d = qen; fcnt_d = fcnt; crc_d = crc;
    take_fs = 1'b0; take_ln = 1'b0; take_fe = 1'b0;
    emit = 1'b0; last = 1'b0; byte_c = 8'h00; di = 8'h00;
    case (st)
      S_IDLE: begin
        cnt_d = 2'd0;
        if (pend_fs) begin
          take_fs = 1'b1; st_d = S_SP; dt_d = DT_FS;
        end else if (pend_ln) begin
          take_ln = 1'b1; st_d = S_SP; dt_d = DT_LS; qen_d = qual_en;
        end else if (pend_fe) begin
          take_fe = 1'b1; st_d = S_SP; dt_d = DT_FE;
        end
      end
      S_SP: begin
        emit = 1'b1;
        di = {vc, dt};
        case (cnt)
          2'd0: byte_c = di;
          2'd1: byte_c = field[7:0];
          2'd2: byte_c = field[15:8];
          default: byte_c = hdr_ecc({field, di});
        endcase
        cnt_d = cnt + 2'd1;
        if (cnt == 2'd3) begin
          last = 1'b1;
          st_d = (dt == DT_LS) ? S_LH : S_IDLE;
          if (dt == DT_FE) fcnt_d = fcnt + 16'd1;
        end
      end
      S_LH: begin
        emit = 1'b1;
        crc_d = 16'hFFFF;
        sidx_d = '0;
        di = {vc, LONG_DT};
        case (cnt)
          2'd0: byte_c = di;
          2'd1: byte_c = wc[7:0];
          2'd2: byte_c = wc[15:8];
          default: byte_c = hdr_ecc({wc, di});
        endcase
        cnt_d = cnt + 2'd1;
        if (cnt == 2'd3) begin
          st_d = S_PL; ph_d = PH_INFO;
        end
      end
      S_PL: begin
        emit = 1'b1;
        case (ph)
          PH_INFO: begin
            case (cnt)
              2'd0: byte_c = prof[7:0];
              2'd1: byte_c = prof[15:8];
              2'd2: byte_c = num[7:0];
              default: byte_c = num[15:8];
            endcase
            cnt_d = cnt + 2'd1;
            if (cnt == 2'd3) begin
              ph_d = PH_SMP; sidx_d = '0; sb_d = '0;
            end
          end
          PH_SMP: begin
            byte_c = smp_rdata[8*int'(sb) +: 8];
            if (sb == SBW'(SBYTES - 1)) begin
              sb_d = '0;
              if (sidx == SAW'(NSAMP - 1)) begin
                if (qen) begin
                  ph_d = PH_QUAL; qidx_d = '0; qb_d = 1'b0;
                end else begin
                  st_d = S_CRC; cnt_d = 2'd0;
                end
              end else begin
                sidx_d = sidx + SAW'(1);
              end
            end else begin
              sb_d = sb + SBW'(1);
            end
          end
          default: begin
            byte_c = qb ? qual_rdata[15:8] : qual_rdata[7:0];
            qb_d = ~qb;
            if (qb) begin
              if (qidx == QAW'(NQUAL - 1)) begin
                st_d = S_CRC; cnt_d = 2'd0;
              end else begin
                qidx_d = qidx + QAW'(1);
              end
            end
          end
        endcase
        crc_d = crc_step(crc, byte_c);
      end
      default: begin
        emit = 1'b1;
        byte_c = (cnt == 2'd0) ? crc[7:0] : crc[15:8];
        cnt_d = cnt + 2'd1;
        if (cnt == 2'd1) begin
          last = 1'b1; st_d = S_SP; dt_d = DT_LE; cnt_d = 2'd0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ph <= PH_INFO; dt <= DT_FS; cnt <= 2'd0;
      sidx <= '0; sb <= '0; qidx <= '0; qb <= 1'b0; qen <= 1'b0;
      fcnt <= 16'd0; crc <= 16'hFFFF;
      pend_fs <= 1'b0; pend_ln <= 1'b0; pend_fe <= 1'b0;
      ob_valid <= 1'b0; ob_data <= 8'h00; ob_last <= 1'b0;
    end else begin
      st <= st_d; ph <= ph_d; dt <= dt_d; cnt <= cnt_d;
      sidx <= sidx_d; sb <= sb_d; qidx <= qidx_d; qb <= qb_d; qen <= qen_d;
      fcnt <= fcnt_d; crc <= crc_d;
      pend_fs <= (pend_fs & ~take_fs) | frame_start;
      pend_ln <= (pend_ln & ~take_ln) | chirp_end;
      pend_fe <= (pend_fe & ~take_fe) | frame_end;
      ob_valid <= emit; ob_data <= byte_c; ob_last <= last;
    end
  end

  logic [15:0] pl_seen;
  always_ff @(posedge clk) begin
    if (rst) pl_seen <= 16'd0;
    else if (st == S_LH) pl_seen <= 16'd0;
    else if (st == S_PL) pl_seen <= pl_seen + 16'd1;
  end

  AST_LS_THEN_HDR: assert property (@(posedge clk) disable iff (rst)
    (st == S_SP && dt == DT_LS && cnt == 2'd3) |=> (st == S_LH)); // R3
  AST_CRC_THEN_LE: assert property (@(posedge clk) disable iff (rst)
    (st == S_CRC && cnt == 2'd1) |=> (st == S_SP && dt == DT_LE && cnt == 2'd0)); // R3
  AST_WC_MATCH: assert property (@(posedge clk) disable iff (rst)
    (st == S_CRC && cnt == 2'd0) |-> (pl_seen == wc)); // R7
endmodule

// File: rtl/pk_lane_dist.sv
module pk_lane_dist #(
  parameter int LANES = 4,
  parameter int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cfg_lanes,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  output logic [LANES*8-1:0] lane_data,
  output logic [LANES-1:0]   lane_valid
);
  logic [7:0]    acc [LANES];
  logic [7:0]    acc_n [LANES];
  logic [LW-1:0] pos;
  logic [LW:0]   nl;
  logic [LANES-1:0] mask;
  logic          flush;

  always_comb begin
    nl = (LW + 1)'(1) << ((int'(cfg_lanes) > LW) ? LW : int'(cfg_lanes));
    for (int k = 0; k < LANES; k++) begin
      acc_n[k] = acc[k];
      mask[k]  = (k < int'(nl));
    end
    acc_n[pos] = in_data;
    flush = in_valid && (({1'b0, pos} == nl - (LW + 1)'(1)) || in_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      lane_valid <= '0;
      lane_data <= '0;
      for (int k = 0; k < LANES; k++) acc[k] <= 8'h00;
    end else begin
      lane_valid <= '0;
      if (in_valid) begin
        if (flush) begin
          for (int k = 0; k < LANES; k++) begin
            lane_data[8*k +: 8] <= acc_n[k];
            acc[k] <= 8'h00;
          end
          lane_valid <= mask;
          pos <= '0;
        end else begin
          for (int k = 0; k < LANES; k++) acc[k] <= acc_n[k];
          pos <= pos + LW'(1);
        end
      end
    end
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, pos} < nl)); // R11
  AST_END_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> (lane_valid != '0)); // R10
endmodule

// File: rtl/pk_chirp_packetizer.sv
module pk_chirp_packetizer #(
  parameter int NSAMP = 16,
  parameter int NQUAL = 2,
  parameter int NCH   = 4,
  parameter int SMP_W = 12,
  parameter int LANES = 4,
  parameter int SDW   = NCH * 2 * SMP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cfg_vc,
  input  logic [1:0]         cfg_lanes,
  input  logic               cfg_qual_en,
  input  logic               frame_start,
  input  logic               frame_end,
  input  logic               chirp_start,
  input  logic [15:0]        chirp_profile,
  input  logic [15:0]        chirp_num,
  input  logic               chirp_end,
  input  logic               smp_valid,
  input  logic [SDW-1:0]     smp_data,
  input  logic               qual_valid,
  input  logic [15:0]        qual_word,
  output logic [LANES*8-1:0] lane_data,
  output logic [LANES-1:0]   lane_valid
);
  localparam int SBYTES = SDW / 8;
  localparam int SAW = (NSAMP > 1) ? $clog2(NSAMP) : 1;
  localparam int QAW = (NQUAL > 1) ? $clog2(NQUAL) : 1;

  logic [15:0]     prof_r, num_r;
  logic [SAW-1:0]  swp, s_raddr;
  logic [QAW-1:0]  qwp, q_raddr;
  logic [SDW-1:0]  s_rdata;
  logic [15:0]     q_rdata;
  logic            s_we, q_we;
  logic            b_valid, b_last;
  logic [7:0]      b_data;

  assign s_we = smp_valid && (int'(swp) < NSAMP);
  assign q_we = qual_valid && (int'(qwp) < NQUAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      prof_r <= 16'd0; num_r <= 16'd0; swp <= '0; qwp <= '0;
    end else if (chirp_start) begin
      prof_r <= chirp_profile; num_r <= chirp_num; swp <= '0; qwp <= '0;
    end else begin
      if (s_we) swp <= swp + SAW'(1);
      if (q_we) qwp <= qwp + QAW'(1);
    end
  end

  pk_line_ram #(.W(SDW), .DEPTH(NSAMP), .AW(SAW)) smp_ram_i (
    .clk(clk), .we(s_we), .waddr(swp), .wdata(smp_data),
    .raddr(s_raddr), .rdata(s_rdata));

  pk_line_ram #(.W(16), .DEPTH(NQUAL), .AW(QAW)) qual_ram_i (
    .clk(clk), .we(q_we), .waddr(qwp), .wdata(qual_word),
    .raddr(q_raddr), .rdata(q_rdata));

  pk_byte_seq #(.NSAMP(NSAMP), .NQUAL(NQUAL), .SBYTES(SBYTES),
                .SAW(SAW), .QAW(QAW)) seq_i (
    .clk(clk), .rst(rst), .vc(cfg_vc), .qual_en(cfg_qual_en),
    .frame_start(frame_start), .frame_end(frame_end), .chirp_end(chirp_end),
    .prof(prof_r), .num(num_r), .smp_rdata(s_rdata), .qual_rdata(q_rdata),
    .smp_raddr(s_raddr), .qual_raddr(q_raddr),
    .ob_valid(b_valid), .ob_data(b_data), .ob_last(b_last));

  pk_lane_dist #(.LANES(LANES)) dist_i (
    .clk(clk), .rst(rst), .cfg_lanes(cfg_lanes),
    .in_valid(b_valid), .in_data(b_data), .in_last(b_last),
    .lane_data(lane_data), .lane_valid(lane_valid));

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $fell(rst) |-> (lane_valid == '0)); // R1
endmodule

// File: tb/pk_chirp_packetizer_tb_top.sv
module pk_chirp_packetizer_tb_top;
  localparam int CLK_NS = 10;
  localparam int NS = 5;
  localparam int NQ = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_vc = 2'd0, cfg_lanes = 2'd2;
  logic cfg_qual_en = 1'b0;
  logic frame_start = 0, frame_end = 0, chirp_start = 0, chirp_end = 0;
  logic [15:0] chirp_profile = 0, chirp_num = 0, qual_word = 0;
  logic smp_valid = 0, qual_valid = 0;
  logic [95:0] smp_data = '0;
  logic [31:0] lane_data;
  logic [3:0]  lane_valid;

  int tests = 0, fails = 0, nl = 4;
  logic [15:0] fcnt = 16'd0;
  bit done = 0;
  logic [7:0] exp_b[$]; string exp_t[$];
  logic [7:0] pkt_b[$]; string pkt_t[$];
  logic [15:0] crc;

  always #(CLK_NS/2) clk = ~clk;

  pk_chirp_packetizer #(.NSAMP(NS), .NQUAL(NQ)) dut_i (
    .clk(clk), .rst(rst), .cfg_vc(cfg_vc), .cfg_lanes(cfg_lanes),
    .cfg_qual_en(cfg_qual_en), .frame_start(frame_start), .frame_end(frame_end),
    .chirp_start(chirp_start), .chirp_profile(chirp_profile), .chirp_num(chirp_num),
    .chirp_end(chirp_end), .smp_valid(smp_valid), .smp_data(smp_data),
    .qual_valid(qual_valid), .qual_word(qual_word),
    .lane_data(lane_data), .lane_valid(lane_valid));

  function automatic logic [7:0] ecc_of(input logic [23:0] d);
    logic [23:0] m [6];
    logic [7:0] e;
    m = '{24'hF12CB7, 24'hF2555B, 24'h749A6D, 24'hB8E38E, 24'hDF03F0, 24'hEFFC00};
    e = 8'h00;
    for (int k = 0; k < 6; k++) begin
      logic p;
      p = 1'b0;
      for (int i = 0; i < 24; i++) if (m[k][i]) p = p ^ d[i];
      e[k] = p;
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic add(input logic [7:0] b, input string t);
    pkt_b.push_back(b); pkt_t.push_back(t);
  endtask

  task automatic addp(input logic [7:0] b, input string t);
    crc = crc ^ {8'h00, b};
    for (int i = 0; i < 8; i++) crc = crc[0] ? ((crc >> 1) ^ 16'h8408) : (crc >> 1);
    add(b, t);
  endtask

  task automatic flush_pkt();
    while (pkt_b.size() % nl != 0) add(8'h00, "R10");
    foreach (pkt_b[i]) begin exp_b.push_back(pkt_b[i]); exp_t.push_back(pkt_t[i]); end
    pkt_b.delete(); pkt_t.delete();
  endtask

  task automatic short_pkt(input logic [5:0] dt, input logic [15:0] f, input string t);
    logic [7:0] di;
    di = {cfg_vc, dt};
    add(di, t); add(f[7:0], t); add(f[15:8], t);
    add(ecc_of({f, di}), "R9");
    flush_pkt();
  endtask

  task automatic pulse_fs();
    short_pkt(6'h00, fcnt, "R2");
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
  endtask

  task automatic pulse_fe();
    short_pkt(6'h01, fcnt, "R2");
    fcnt++;
    @(negedge clk) frame_end = 1;
    @(negedge clk) frame_end = 0;
    repeat (40) @(negedge clk);
  endtask

  task automatic drain_check();
    repeat (200) @(negedge clk);
    check(exp_b.size() == 0, "R10 drained", exp_b.size(), 0);
  endtask

  task automatic do_chirp(input logic [15:0] prof, input logic [15:0] num, input bit with_fe);
    logic [11:0] si [NS][4];
    logic [11:0] sq [NS][4];
    logic [15:0] qw [NQ];
    logic [15:0] wc;
    logic [7:0] di;
    @(negedge clk) begin chirp_start = 1; chirp_profile = prof; chirp_num = num; end
    @(negedge clk) chirp_start = 0;
    for (int s = 0; s < NS; s++) begin
      for (int c = 0; c < 4; c++) begin
        si[s][c] = 12'($urandom); sq[s][c] = 12'($urandom);
        smp_data[24*c +: 24] = {sq[s][c], si[s][c]};
      end
      smp_valid = 1;
      @(negedge clk);
    end
    smp_valid = 0;
    for (int q = 0; q < NQ; q++) begin
      qw[q] = 16'($urandom); qual_word = qw[q]; qual_valid = 1;
      @(negedge clk);
    end
    qual_valid = 0;
    short_pkt(6'h02, num, "R3");
    wc = 16'(4 + 12 * NS + (cfg_qual_en ? 2 * NQ : 0));
    di = {cfg_vc, 6'h2C};
    add(di, "R4"); add(wc[7:0], "R7"); add(wc[15:8], "R7"); add(ecc_of({wc, di}), "R9");
    crc = 16'hFFFF;
    addp(prof[7:0], "R5"); addp(prof[15:8], "R5"); addp(num[7:0], "R5"); addp(num[15:8], "R5");
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < 4; c++) begin
        addp(si[s][c][7:0], "R6");
        addp({sq[s][c][3:0], si[s][c][11:8]}, "R6");
        addp(sq[s][c][11:4], "R6");
      end
    if (cfg_qual_en)
      for (int q = 0; q < NQ; q++) begin addp(qw[q][7:0], "R7"); addp(qw[q][15:8], "R7"); end
    add(crc[7:0], "R8"); add(crc[15:8], "R8");
    flush_pkt();
    short_pkt(6'h03, num, "R3");
    if (with_fe) begin short_pkt(6'h01, fcnt, "R12"); fcnt++; end
    chirp_end = 1; frame_end = with_fe;
    @(negedge clk) begin chirp_end = 0; frame_end = 0; end
    repeat (250) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && lane_valid != 4'd0) begin
      logic [3:0] em;
      em = 4'((1 << nl) - 1);
      check(lane_valid == em, "R10/R11 lane mask", lane_valid, em);
      for (int k = 0; k < nl; k++) begin
        if (exp_b.size() == 0) check(1'b0, "R10 unexpected byte", lane_data[8*k +: 8], 0);
        else begin
          logic [7:0] eb; string et;
          eb = exp_b.pop_front(); et = exp_t.pop_front();
          check(lane_data[8*k +: 8] == eb, et, lane_data[8*k +: 8], eb);
        end
      end
    end
  end

  task automatic set_lanes(input logic [1:0] c);
    cfg_lanes = c;
    nl = (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    set_lanes(2'd2);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(lane_valid == 4'd0, "R1 valid", lane_valid, 0);
    check(lane_data == 32'd0, "R1 data", lane_data, 0);

    // four lanes, quality on, vc 1 (R5 R6 R7 R8 R10)
    cfg_vc = 2'd1; cfg_qual_en = 1;
    pulse_fs();
    do_chirp(16'hA51C, 16'h0001, 0);
    do_chirp(16'h3C7E, 16'h0002, 0);
    pulse_fe();
    drain_check();

    // two lanes, quality off, coinciding chirp end and frame end (R11 R12)
    set_lanes(2'd1); cfg_vc = 2'd2; cfg_qual_en = 0;
    pulse_fs();
    do_chirp(16'h0F0F, 16'h1234, 0);
    do_chirp(16'hFFFF, 16'h1235, 1);
    drain_check();

    // one lane, quality on, vc 3 (R11)
    set_lanes(2'd0); cfg_vc = 2'd3; cfg_qual_en = 1;
    pulse_fs();
    do_chirp(16'h0000, 16'hBEEF, 1);
    drain_check();

    // alias value 3 means four lanes, quality off gives padded end (R10 R11)
    set_lanes(2'd3); cfg_vc = 2'd0; cfg_qual_en = 0;
    pulse_fs();
    do_chirp(16'h8001, 16'h7FFE, 0);
    pulse_fe();
    drain_check();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule